// File: doc/BRIEF.md
# Gain-Corrected CORDIC Vector Rotator

This block turns a signed fixed-point pair (x, y) through an angle that a companion arctangent (vectoring) unit has produced. It is one of the two building blocks of a multiplier-free QR-decomposition array. A vectoring cell measures the angle of a leading pair. Rotator cells then apply that same angle to every other pair in the two rows being combined. Because the angle is applied in the same sense as the vectoring measurement, feeding a pair back in with its own angle leaves the length in x and clears y.

Internally the block works one iteration at a time. An input beyond a quarter turn is first folded by an exact 90-degree swap. A fixed number of arctangent micro-rotations then run, and their direction is chosen by the sign of the residual angle. A short chain of shift-and-add terms removes the CORDIC length growth, and the result is clamped to the output range. The handshake is valid/ready on both sides. The block holds one transaction at a time and keeps its result on the output until it is taken.

Top module: `crot_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `out_valid` is 0, `in_ready` is 1 and `out_x`/`out_y` are 0.
- R2: The outputs satisfy x' = x·cos(a) + y·sin(a) and y' = y·cos(a) − x·sin(a), to within 6 LSB. Here x and y are two's-complement integers of DATA_W bits, and a = `in_ang`·π / 2^(ANG_W−1), with `in_ang` a two's-complement binary angle (0x4000 is +π/2 and 0x8000 is −π at ANG_W=16).
- R3: The R2 relation holds over the whole angle range [−π, π), including angles beyond ±π/2 and the code −π itself.
- R4: If the angle is the one a vectoring unit measures for the same pair, a = atan2(y, x) in the R2 encoding, then y' lies within 8 LSB of 0 and x' within 8 LSB of the pair's length (clamped as in R6).
- R5: The outputs carry no CORDIC length growth. A pair rotated by angle 0 comes back with its own values within 6 LSB, not about 1.647 times them.
- R6: A result above 2^(DATA_W−1)−1 is output as 2^(DATA_W−1)−1, and a result below −2^(DATA_W−1) is output as −2^(DATA_W−1). Results never wrap.
- R7: An input is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the result has been taken, and inputs presented during that time have no effect on the result.
- R8: `out_valid` rises once for each input taken, and `out_x`/`out_y` stay unchanged while `out_valid` is 1 and `out_ready` is 0. After a cycle with `out_valid` and `out_ready` both 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair and angle are present |
| in_ready | output | 1 | Block is idle and can take an input |
| in_x | input | DATA_W | Signed x component |
| in_y | input | DATA_W | Signed y component |
| in_ang | input | ANG_W | Signed binary angle, full scale ±π |
| out_valid | output | 1 | Rotated result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | DATA_W | Rotated, gain-corrected, clamped x |
| out_y | output | DATA_W | Rotated, gain-corrected, clamped y |

## Verification
The bench aims at angles past ±π/2 and the −π code. A design whose quarter-turn fold is wrong or missing gives results that are off by a large angle there. It feeds pairs together with their own vectoring angle, which catches a design that turns the wrong way: such a design doubles the angle instead of clearing y. Pairs near full scale, rotated so the length lands on one axis, show whether the output clamps or wraps to the opposite sign. A zero-angle case shows whether the gain correction is missing, which would show as a factor of about 1.647. Handshake tests hold `out_ready` low and present new inputs while the block is busy. A design that let the result drift, or took the second input, would return wrong values.

// File: rtl/crot_pkg.sv
package crot_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAIN, ST_DONE} crot_state_e;

  // Inverse CORDIC gain ~0.6072529 as signed power-of-two terms:
  // 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-12 + 2^-14
  localparam int GAIN_TERMS = 6;
  localparam int GAIN_SHIFT [GAIN_TERMS] = '{1, 3, 6, 9, 12, 14};
  localparam bit GAIN_NEG   [GAIN_TERMS] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  // atan(2^-i) on a scale where 2^23 equals pi (up to 16 steps)
  function automatic int atan_ref24(input int idx);
    case (idx)
      0:  return 2097152;
      1:  return 1238021;
      2:  return 654136;
      3:  return 332050;
      4:  return 166669;
      5:  return 83416;
      6:  return 41718;
      7:  return 20860;
      8:  return 10430;
      9:  return 5215;
      10: return 2608;
      11: return 1304;
      12: return 652;
      13: return 326;
      14: return 163;
      15: return 81;
      default: return 0;
    endcase
  endfunction

  // Same value rescaled so that 2^(aw-1) equals pi (aw <= 24)
  function automatic int atan_code(input int idx, input int aw);
    int s;
    s = 24 - aw;
    if (s > 0) return (atan_ref24(idx) + (1 << (s - 1))) >>> s;
    return atan_ref24(idx);
  endfunction

endpackage

// File: rtl/crot_prefold.sv
module crot_prefold #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int GUARD  = 4,
  localparam int XW    = DATA_W + 2 + GUARD
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_i,
  input  logic signed [ANG_W-1:0]  ang_i,
  output logic signed [XW-1:0]     x_o,
  output logic signed [XW-1:0]     y_o,
  output logic signed [ANG_W-1:0]  z_o
);
  localparam logic signed [ANG_W-1:0] QUARTER = ANG_W'(1 << (ANG_W - 2));

  logic signed [XW-1:0] xe, ye;

  assign xe = {{2{x_i[DATA_W-1]}}, x_i, {GUARD{1'b0}}};
  assign ye = {{2{y_i[DATA_W-1]}}, y_i, {GUARD{1'b0}}};

  always_comb begin
    if (ang_i > QUARTER) begin
      // clockwise quarter turn: (x, y) -> (y, -x)
      x_o = ye;
      y_o = -xe;
      z_o = ang_i - QUARTER;
    end else if (ang_i < -QUARTER) begin
      // counter-clockwise quarter turn: (x, y) -> (-y, x)
      x_o = -ye;
      y_o = xe;
      z_o = ang_i + QUARTER;
    end else begin
      x_o = xe;
      y_o = ye;
      z_o = ang_i;
    end
  end
endmodule

// File: rtl/crot_micro.sv
module crot_micro #(
  parameter int XW    = 22,
  parameter int ANG_W = 16,
  parameter int CW    = 5
) (
  input  logic signed [XW-1:0]    x_i,
  input  logic signed [XW-1:0]    y_i,
  input  logic signed [ANG_W-1:0] z_i,
  input  logic [CW-1:0]           step_i,
  output logic signed [XW-1:0]    x_o,
  output logic signed [XW-1:0]    y_o,
  output logic signed [ANG_W-1:0] z_o
);
  import crot_pkg::*;

  logic signed [XW-1:0]    xs, ys;
  logic signed [ANG_W-1:0] a_step;

  assign xs     = x_i >>> step_i;
  assign ys     = y_i >>> step_i;
  assign a_step = ANG_W'(atan_code(int'(step_i), ANG_W));

  always_comb begin
    if (!z_i[ANG_W-1]) begin
      // residual positive: turn clockwise
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i - a_step;
    end else begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i + a_step;
    end
  end
endmodule

// File: rtl/crot_gain.sv
module crot_gain #(
  parameter int DATA_W = 16,
  parameter int GUARD  = 4,
  localparam int XW    = DATA_W + 2 + GUARD
) (
  input  logic signed [XW-1:0]     x_i,
  input  logic signed [XW-1:0]     y_i,
  output logic signed [DATA_W-1:0] x_o,
  output logic signed [DATA_W-1:0] y_o
);
  import crot_pkg::*;

  localparam logic signed [XW-1:0] SAT_HI = {{(XW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [XW-1:0] SAT_LO = {{(XW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  function automatic logic signed [XW-1:0] scale(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] acc;
    acc = '0;
    for (int k = 0; k < GAIN_TERMS; k++) begin
      if (GAIN_NEG[k]) acc = acc - (v >>> GAIN_SHIFT[k]);
      else             acc = acc + (v >>> GAIN_SHIFT[k]);
    end
    return acc >>> GUARD;
  endfunction

  function automatic logic signed [DATA_W-1:0] clamp(input logic signed [XW-1:0] v);
    if (v > SAT_HI) return SAT_HI[DATA_W-1:0];
    if (v < SAT_LO) return SAT_LO[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  logic signed [XW-1:0] xg, yg;

  assign xg  = scale(x_i);
  assign yg  = scale(y_i);
  assign x_o = clamp(xg);
  assign y_o = clamp(yg);
endmodule

// File: rtl/crot_unit.sv
module crot_unit #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,   // at most 24
  parameter int ITER   = 16,   // at most 16
  parameter int GUARD  = 4,
  localparam int XW    = DATA_W + 2 + GUARD,
  localparam int CW    = $clog2(ITER) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [DATA_W-1:0] in_y,
  input  logic signed [ANG_W-1:0]  in_ang,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_x,
  output logic signed [DATA_W-1:0] out_y
);
  import crot_pkg::*;

  localparam logic signed [ANG_W-1:0] QUARTER = ANG_W'(1 << (ANG_W - 2));

  crot_state_e             state;
  logic [CW-1:0]           cnt;
  logic signed [XW-1:0]    xr, yr, fx, fy, nx, ny;
  logic signed [ANG_W-1:0] zr, fz, nz;
  logic signed [DATA_W-1:0] gx, gy;

  crot_prefold #(.DATA_W(DATA_W), .ANG_W(ANG_W), .GUARD(GUARD)) u_fold (
    .x_i(in_x), .y_i(in_y), .ang_i(in_ang), .x_o(fx), .y_o(fy), .z_o(fz)
  );

  crot_micro #(.XW(XW), .ANG_W(ANG_W), .CW(CW)) u_step (
    .x_i(xr), .y_i(yr), .z_i(zr), .step_i(cnt), .x_o(nx), .y_o(ny), .z_o(nz)
  );

  crot_gain #(.DATA_W(DATA_W), .GUARD(GUARD)) u_gain (
    .x_i(xr), .y_i(yr), .x_o(gx), .y_o(gy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      xr        <= '0;
      yr        <= '0;
      zr        <= '0;
      out_x     <= '0;
      out_y     <= '0;
      out_valid <= 1'b0;
      in_ready  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (in_valid && in_ready) begin
          xr       <= fx;
          yr       <= fy;
          zr       <= fz;
          cnt      <= '0;
          in_ready <= 1'b0;
          state    <= ST_RUN;
        end
        ST_RUN: begin
          xr  <= nx;
          yr  <= ny;
          zr  <= nz;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ITER - 1)) state <= ST_GAIN;
        end
        ST_GAIN: begin
          out_x     <= gx;
          out_y     <= gy;
          out_valid <= 1'b1;
          state     <= ST_DONE;
        end
        default: if (out_ready) begin
          out_valid <= 1'b0;
          in_ready  <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R1: reset leaves the block idle with no result pending
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  // R3: the quarter-turn fold leaves a residual within +/- pi/2
  assert_fold_range_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt == '0) |-> (zr <= QUARTER && zr >= -QUARTER));

  // R7: an accepted input closes the input side
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R7: input side and output side are never open together
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R8: a pending result is held unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)));

  // R8: a taken result is withdrawn and the input side reopens
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

// File: tb/crot_unit_tb.sv
module crot_unit_tb;
  localparam int  DW  = 16;
  localparam int  AW  = 16;
  localparam real PI  = 3.14159265358979;
  localparam int  TOL = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [DW-1:0] in_x = '0, in_y = '0;
  logic signed [AW-1:0] in_ang = '0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] out_x, out_y;

  int n_chk = 0;
  int n_bad = 0;
  int got_x, got_y;

  always #5 clk = ~clk;

  crot_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_ang(in_ang), .out_valid(out_valid),
    .out_ready(out_ready), .out_x(out_x), .out_y(out_y)
  );

  function automatic int clampi(input real v);
    int r;
    if (v > 32767.0) return 32767;
    if (v < -32768.0) return -32768;
    r = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    return r;
  endfunction

  function automatic int exp_x(input int x, input int y, input int a);
    real t;
    t = a * PI / 32768.0;
    return clampi(x * $cos(t) + y * $sin(t));
  endfunction

  function automatic int exp_y(input int x, input int y, input int a);
    real t;
    t = a * PI / 32768.0;
    return clampi(y * $cos(t) - x * $sin(t));
  endfunction

  task automatic check(input string tag, input int act, input int expv, input int tol);
    int d;
    n_chk++;
    d = act - expv;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic issue(input int x, input int y, input int a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_x = DW'(x); in_y = DW'(y); in_ang = AW'(a);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect();
    while (!out_valid) @(negedge clk);
    got_x = int'(out_x);
    got_y = int'(out_y);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic rotate_check(input string tag, input int x, input int y, input int a);
    issue(x, y, a);
    collect();
    check({tag, " x"}, got_x, exp_x(x, y, a), TOL);
    check({tag, " y"}, got_y, exp_y(x, y, a), TOL);
  endtask

  task automatic t_reset();
    check("R1 out_valid", int'(out_valid), 0, 0);
    check("R1 in_ready", int'(in_ready), 1, 0);
    check("R1 out_x", int'(out_x), 0, 0);
    check("R1 out_y", int'(out_y), 0, 0);
  endtask

  task automatic t_in_range();
    int s = 12345;
    rotate_check("R2 fixed", 12000, -7000, 5000);
    rotate_check("R2 neg", -15000, 9000, -12000);
    for (int i = 0; i < 12; i++) begin
      int x, y, a;
      s = s * 1103515245 + 12345; x = ((s >>> 8) % 20000);
      s = s * 1103515245 + 12345; y = ((s >>> 8) % 20000);
      s = s * 1103515245 + 12345; a = ((s >>> 8) % 16384);
      rotate_check("R2 sweep", x, y, a);
    end
  endtask

  task automatic t_wide_angles();
    rotate_check("R3 above", 10000, 4000, 20000);
    rotate_check("R3 below", -8000, 11000, -25000);
    rotate_check("R3 minus_pi", 13000, -6000, -32768);
    rotate_check("R3 near_pi", 9000, 9000, 32767);
    rotate_check("R3 three_q", -5000, -14000, 24576);
  endtask

  task automatic t_eliminate();
    int xs [4] = '{15000, -9000, 3000, -12000};
    int ys [4] = '{8000, 11000, -16000, -5000};
    for (int i = 0; i < 4; i++) begin
      int a;
      real r;
      a = $rtoi($atan2(real'(ys[i]), real'(xs[i])) * 32768.0 / PI + (ys[i] >= 0 ? 0.5 : -0.5));
      r = $sqrt(real'(xs[i]) * xs[i] + real'(ys[i]) * ys[i]);
      issue(xs[i], ys[i], a);
      collect();
      check("R4 length", got_x, clampi(r), 8);
      check("R4 zero_y", got_y, 0, 8);
    end
  endtask

  task automatic t_gain();
    issue(10000, -20000, 0);
    collect();
    check("R5 unity x", got_x, 10000, TOL);
    check("R5 unity y", got_y, -20000, TOL);
  endtask

  task automatic t_saturate();
    issue(32767, 32767, 8192);
    collect();
    check("R6 clamp_hi", got_x, 32767, 0);
    issue(-32768, -32768, 8192);
    collect();
    check("R6 clamp_lo", got_x, -32768, 0);
    issue(30000, -30000, 8192);
    collect();
    check("R6 clamp_y_lo", got_y, -32768, 0);
  endtask

  task automatic t_handshake();
    int hx, hy;
    issue(14000, 3000, 3000);
    check("R7 busy", int'(in_ready), 0, 0);
    in_x = DW'(-20000); in_y = DW'(25000); in_ang = AW'(-9000);
    in_valid = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    check("R7 busy_done", int'(in_ready), 0, 0);
    hx = int'(out_x); hy = int'(out_y);
    for (int i = 0; i < 6; i++) @(negedge clk);
    check("R8 held_valid", int'(out_valid), 1, 0);
    check("R8 held_x", int'(out_x), hx, 0);
    check("R8 held_y", int'(out_y), hy, 0);
    collect();
    check("R7 ignored x", got_x, exp_x(14000, 3000, 3000), TOL);
    check("R7 ignored y", got_y, exp_y(14000, 3000, 3000), TOL);
    check("R8 released", int'(out_valid), 0, 0);
    check("R8 reopened", int'(in_ready), 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_in_range();
    t_wide_angles();
    t_eliminate();
    t_gain();
    t_saturate();
    t_handshake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule